// File: doc/BRIEF.md
# Pixel Gain/Offset Code Receiver

This block takes per-pixel gain and offset codes for the three colour channels of a scanner front end from a 10-bit parallel bus. Both clock edges carry data: a gain word is taken on each rising edge of the converter clock and an offset word on the falling edge that follows it. The pixel strobe marks the start of each pixel. In three-channel mode the converter clock runs at three times the pixel rate and the bus carries red, green and blue pairs in turn. In single-channel mode it carries one pair per pixel.

The words of a pixel are collected in a shadow set. On the next pixel strobe, the six output registers load from that shadow set together, but only if the input enable is high at the strobe edge. Codes received during one pixel therefore drive the outputs for the next pixel. Offset words taken on the falling edge are moved into the rising-edge domain before they are used, so every register update happens on the rising edge.

Top module: `pixcal_rx`

## Requirements
- R1: While reset is active and after it is released, all six output registers read zero until the first enabled pixel strobe loads them.
- R2: The gain word is the bus value at the rising clock edge. The offset word is the bus value at the falling edge that follows. Bus values between the edges have no effect.
- R3: In three-channel mode (`tri_mode` = 1), the rising edge where `pix_strobe` is high carries the red gain. The next two rising edges carry green and blue. Each gain is followed by its offset on the next falling edge.
- R4: In single-channel mode (`tri_mode` = 0), every rising edge carries a red gain, with its red offset on the next falling edge. The green and blue outputs keep their values.
- R5: At a rising edge where `pix_strobe` and `load_en` are both high, all six outputs load the codes received during the previous pixel. This includes the last offset, taken on the falling edge just before the strobe edge.
- R6: If `load_en` is low at a strobe edge, all outputs keep their previous values. The level of `load_en` at edges without a strobe has no effect.
- R7: A rising edge where `tri_mode` differs from its value at the previous edge restarts the channel order at red, even without a strobe.
- R8: In three-channel mode without a strobe, the channel after blue is red again.
- R9: The outputs change only at a rising edge where `pix_strobe` and `load_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; gain sampled on rise, offset on fall |
| rst_n | input | 1 | Asynchronous active-low reset |
| tri_mode | input | 1 | 1 = three-channel, 0 = single-channel |
| pix_strobe | input | 1 | Pixel start, sampled at the rising edge that carries the red gain |
| load_en | input | 1 | Enables the output load at a strobe edge |
| cal_bus | input | 10 | Shared gain/offset code bus |
| gain_r | output | 10 | Active red gain code |
| gain_g | output | 10 | Active green gain code |
| gain_b | output | 10 | Active blue gain code |
| offs_r | output | 10 | Active red offset code |
| offs_g | output | 10 | Active green offset code |
| offs_b | output | 10 | Active blue offset code |

## Verification
The bench targets the blue offset that arrives on the falling edge just before a strobe. A design that loaded the outputs without first merging that word would show a stale blue offset one pixel late. It sends pixels with the enable high on the channel edges but low at the strobe; a design that latched the enable anywhere other than the strobe edge would load when it should hold. It switches modes without a strobe and adds a fourth edge after blue. A sequencer that failed to restart or wrap would send those words to green or blue. It also drives garbage on the bus between edges, which exposes any capture taken on the wrong edge.

// File: rtl/pixcal_pkg.sv
package pixcal_pkg;
  localparam int NCH = 3;
  localparam int SLOT_W = $clog2(NCH);
  typedef logic [SLOT_W-1:0] slot_t;

  // channel following s; restart forces red
  function automatic slot_t slot_advance(slot_t s, logic restart);
    slot_t r;
    if (restart) r = '0;
    else if (s == slot_t'(NCH - 1)) r = '0;
    else r = s + slot_t'(1);
    return r;
  endfunction
endpackage

// File: rtl/pixcal_fall_cap.sv
module pixcal_fall_cap #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] off_fall
);
  // offset word taken on the falling edge; consumed at the next rising edge
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) off_fall <= '0;
    else        off_fall <= bus_in;
  end
endmodule

// File: rtl/pixcal_seq.sv
module pixcal_seq
  import pixcal_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tri_mode,
  input  logic  pix_strobe,
  output slot_t slot_now,
  output slot_t slot_q,
  output logic  pend_vld,
  output logic  mode_chg
);
  logic mode_q;

  assign mode_chg = (tri_mode != mode_q);
  assign slot_now = slot_advance(slot_q, pix_strobe | mode_chg | ~tri_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= '0;
      mode_q   <= 1'b1;
      pend_vld <= 1'b0;
    end else begin
      slot_q   <= slot_now;
      mode_q   <= tri_mode;
      pend_vld <= 1'b1;
    end
  end

  AST_STROBE_RED: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |=> slot_q == '0); // R3
  AST_SINGLE_RED: assert property (@(posedge clk) disable iff (!rst_n)
    !tri_mode |=> slot_q == '0); // R4
  AST_MODECHG_RED: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> slot_q == '0); // R7
  AST_WRAP_RED: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_mode && !pix_strobe && !mode_chg && slot_q == slot_t'(NCH-1)) |=> slot_q == '0); // R8
endmodule

// File: rtl/pixcal_shadow.sv
module pixcal_shadow
  import pixcal_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   bus_in,
  input  logic [DW-1:0]   off_fall,
  input  slot_t           slot_now,
  input  slot_t           slot_q,
  input  logic            pend_vld,
  output logic [NCH*DW-1:0] sh_gain,
  output logic [NCH*DW-1:0] sh_off_done
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] gain_reg, off_reg;
    logic          off_hit;

    assign off_hit = pend_vld && (slot_q == slot_t'(c));
    // offset set completed with the word retimed from the falling edge
    assign sh_off_done[c*DW +: DW] = off_hit ? off_fall : off_reg;
    assign sh_gain[c*DW +: DW]     = gain_reg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gain_reg <= '0;
        off_reg  <= '0;
      end else begin
        if (slot_now == slot_t'(c)) gain_reg <= bus_in;
        off_reg <= sh_off_done[c*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/pixcal_commit.sv
module pixcal_commit
  import pixcal_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NCH*DW-1:0] sh_gain,
  input  logic [NCH*DW-1:0] sh_off,
  output logic [NCH*DW-1:0] act_gain,
  output logic [NCH*DW-1:0] act_off
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_gain <= '0;
      act_off  <= '0;
    end else if (load) begin
      act_gain <= sh_gain;
      act_off  <= sh_off;
    end
  end
endmodule

// File: rtl/pixcal_rx.sv
module pixcal_rx
  import pixcal_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tri_mode,
  input  logic          pix_strobe,
  input  logic          load_en,
  input  logic [DW-1:0] cal_bus,
  output logic [DW-1:0] gain_r,
  output logic [DW-1:0] gain_g,
  output logic [DW-1:0] gain_b,
  output logic [DW-1:0] offs_r,
  output logic [DW-1:0] offs_g,
  output logic [DW-1:0] offs_b
);
  localparam int SETW = NCH * DW;

  logic [DW-1:0]   off_fall;
  slot_t           slot_now, slot_q;
  logic            pend_vld, mode_chg;
  logic [SETW-1:0] sh_gain, sh_off_done, act_gain, act_off;
  logic            commit_evt;

  assign commit_evt = pix_strobe & load_en;

  pixcal_fall_cap #(.DW(DW)) u_fall (
    .clk(clk), .rst_n(rst_n), .bus_in(cal_bus), .off_fall(off_fall));

  pixcal_seq u_seq (
    .clk(clk), .rst_n(rst_n), .tri_mode(tri_mode), .pix_strobe(pix_strobe),
    .slot_now(slot_now), .slot_q(slot_q), .pend_vld(pend_vld), .mode_chg(mode_chg));

  pixcal_shadow #(.DW(DW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .bus_in(cal_bus), .off_fall(off_fall),
    .slot_now(slot_now), .slot_q(slot_q), .pend_vld(pend_vld),
    .sh_gain(sh_gain), .sh_off_done(sh_off_done));

  pixcal_commit #(.DW(DW)) u_commit (
    .clk(clk), .rst_n(rst_n), .load(commit_evt),
    .sh_gain(sh_gain), .sh_off(sh_off_done),
    .act_gain(act_gain), .act_off(act_off));

  assign gain_r = act_gain[0*DW +: DW];
  assign gain_g = act_gain[1*DW +: DW];
  assign gain_b = act_gain[2*DW +: DW];
  assign offs_r = act_off[0*DW +: DW];
  assign offs_g = act_off[1*DW +: DW];
  assign offs_b = act_off[2*DW +: DW];

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable({gain_r, gain_g, gain_b, offs_r, offs_g, offs_b})); // R9
  AST_LOAD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> ({gain_b, gain_g, gain_r} == $past(sh_gain)
                  && {offs_b, offs_g, offs_r} == $past(sh_off_done))); // R5
  AST_HOLD_LOW_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_strobe && !load_en) |=> $stable({gain_r, gain_g, gain_b, offs_r, offs_g, offs_b})); // R6
  always_comb begin
    if (!rst_n) AST_RESET_ZERO: assert (act_gain == '0 && act_off == '0); // R1
  end
endmodule

// File: tb/test_pixcal_rx.sv
module test_pixcal_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tri_mode = 1'b1;
  logic       pix_strobe = 1'b0;
  logic       load_en = 1'b0;
  logic [9:0] cal_bus = '0;
  logic [9:0] gain_r, gain_g, gain_b, offs_r, offs_g, offs_b;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model: pixel under collection and active values
  logic [9:0] m_gain[3], m_off[3];
  logic [9:0] e_gain[3], e_off[3];

  always #4 clk = ~clk;

  pixcal_rx i_pixcal_rx (
    .clk(clk), .rst_n(rst_n), .tri_mode(tri_mode), .pix_strobe(pix_strobe),
    .load_en(load_en), .cal_bus(cal_bus),
    .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
    .offs_r(offs_r), .offs_g(offs_g), .offs_b(offs_b));

  task automatic chk(string tag, logic [9:0] act, logic [9:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " gain_r"}, gain_r, e_gain[0]);
    chk({tag, " gain_g"}, gain_g, e_gain[1]);
    chk({tag, " gain_b"}, gain_b, e_gain[2]);
    chk({tag, " offs_r"}, offs_r, e_off[0]);
    chk({tag, " offs_g"}, offs_g, e_off[1]);
    chk({tag, " offs_b"}, offs_b, e_off[2]);
  endtask

  // one converter clock: gain before rise, offset before fall, garbage after (R2)
  task automatic step(logic [9:0] g, logic [9:0] o, logic s, logic e);
    cal_bus = g; pix_strobe = s; load_en = e;
    @(posedge clk); #1;
    cal_bus = o; pix_strobe = 1'b0; load_en = 1'b0;
    @(negedge clk); #1;
    cal_bus = 10'($urandom);
  endtask

  function automatic void model_load(logic en);
    if (en) for (int c = 0; c < 3; c++) begin
      e_gain[c] = m_gain[c]; e_off[c] = m_off[c];
    end
  endfunction

  // three-channel pixel; en_mid drives load_en on non-strobe edges (R6)
  task automatic px3(string tag, logic en, logic en_mid);
    logic [9:0] g[3], o[3];
    for (int c = 0; c < 3; c++) begin g[c] = 10'($urandom); o[c] = 10'($urandom); end
    step(g[0], o[0], 1'b1, en);
    model_load(en);
    chk_all(tag);
    step(g[1], o[1], 1'b0, en_mid);
    step(g[2], o[2], 1'b0, en_mid);
    for (int c = 0; c < 3; c++) begin m_gain[c] = g[c]; m_off[c] = o[c]; end
  endtask

  task automatic px1(string tag, logic en);
    logic [9:0] g, o;
    g = 10'($urandom); o = 10'($urandom);
    step(g, o, 1'b1, en);
    model_load(en);
    chk_all(tag);
    m_gain[0] = g; m_off[0] = o;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 3; c++) begin
      m_gain[c] = '0; m_off[c] = '0; e_gain[c] = '0; e_off[c] = '0;
    end
    repeat (3) @(negedge clk);
    chk_all("R1 in reset");
    #1 rst_n = 1'b1;
    @(negedge clk); #1;
    chk_all("R1 after reset");

    // R3 R5 directed three-channel pixels, first load carries the reset shadow
    px3("R3 first", 1'b1, 1'b0);
    px3("R3 R5 load", 1'b1, 1'b0);
    px3("R2 R5 load", 1'b1, 1'b0);

    // R6 enable high between strobes, low at strobe: hold
    px3("R6 hold", 1'b0, 1'b1);
    px3("R6 hold again", 1'b0, 1'b1);
    px3("R6 load after hold", 1'b1, 1'b0);

    // R8 extra edge after blue lands on red
    begin
      logic [9:0] gx, ox;
      gx = 10'h2A5; ox = 10'h15A;
      step(gx, ox, 1'b0, 1'b0);
      m_gain[0] = gx; m_off[0] = ox;
      px3("R8 wrap", 1'b1, 1'b0);
    end

    // R4 single-channel: only red moves
    tri_mode = 1'b0;
    px1("R4 enter single", 1'b1);
    px1("R4 single", 1'b1);
    px1("R4 single", 1'b1);
    px1("R4 R6 single hold", 1'b0);

    // R7 mode change without strobe restarts at red
    tri_mode = 1'b1;
    begin
      logic [9:0] g[3], o[3];
      for (int c = 0; c < 3; c++) begin g[c] = 10'($urandom); o[c] = 10'($urandom); end
      for (int c = 0; c < 3; c++) step(g[c], o[c], 1'b0, 1'b1);
      chk_all("R7 no load without strobe");
      for (int c = 0; c < 3; c++) begin m_gain[c] = g[c]; m_off[c] = o[c]; end
      px3("R7 restart red", 1'b1, 1'b0);
    end

    // random mix
    for (int k = 0; k < 60; k++) begin
      logic want_tri, en;
      want_tri = ($urandom % 4) != 0;
      en = ($urandom % 3) != 0;
      tri_mode = want_tri;
      if (want_tri) px3("R3 R5 R6 random", en, 1'($urandom));
      else          px1("R4 R5 R6 random", en);
    end
    tri_mode = 1'b1;
    px3("R5 final", 1'b1, 1'b0);
    px3("R5 final", 1'b1, 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule